// File: doc/BRIEF.md
# NAND Page Storage Array

This block is the storage core of a small NAND flash model. It holds a grid of pages. Each page has a main area and a spare area one thirty-second the size of the main area. Pages are grouped into erase blocks. Stored bits follow flash rules: a program can only move a bit from 1 to 0, and only a block erase brings bits back to 1. Out of reset every cell reads 0xFF.

A host opens a program by giving a start address. It then streams bytes into a staging image of one page row and commits that image. The commit merges the image into the array with a bitwise AND. An erase request names any address inside a block and clears that whole block, spare bytes included, back to 0xFF. A load request streams the bytes of a page out, one per cycle, from a column to the end of the row. When the spare-disable input is set, the stream stops at the end of the main area.

An address splits into a page index (the bits at and above `ADDR_SHIFT`) and a column (the bits below it). A program commit or an erase that is accepted holds `busy` for a fixed number of cycles and then pulses `done`. The block takes no new commit, erase or load while it is busy or streaming.

Top module: `nand_page_store`

## Requirements
- R1: While `rst` is held high the block clears itself. Afterwards every byte of every page, main and spare, reads 0xFF, and `busy`, `done` and `rd_valid` are low.
- R2: A commit ANDs each staged byte into the stored byte at the same column. A column where no byte was staged is left unchanged.
- R3: A row holds PAGE_BYTES main bytes followed by PAGE_BYTES/32 spare bytes, at columns PAGE_BYTES and up. A byte stream that runs past the end of the main area lands in the spare bytes.
- R4: The page index is `req_addr[ADDR_W-1:ADDR_SHIFT]` and the column is `req_addr[ADDR_SHIFT-1:0]`. A program writes only to the page captured when it was opened, and its first byte lands at the captured column.
- R5: An erase aligns the page index down to a multiple of 2^ERASE_SHIFT. It sets every byte of those pages, spare included, to 0xFF and leaves all other pages untouched.
- R6: A load accepted at column c gives one byte per cycle with `rd_valid` high. It gives PAGE_BYTES+PAGE_BYTES/32−c bytes, or PAGE_BYTES−c bytes if `spare_off` was high when it was accepted. `rd_last` is high on the final byte only.
- R7: A commit, erase or load whose page index is NUM_PAGES or more is ignored: no `busy`, no stream, and the array is unchanged.
- R8: An accepted commit or erase holds `busy` high for exactly BUSY_CYCLES cycles. In the cycle after the last busy cycle, `done` is high for one cycle.
- R9: A commit, erase or load requested while `busy` or `rd_valid` is high is dropped, with no later effect.
- R10: After an accepted commit the staging image returns to all 0xFF and its write column returns to 0. Bytes streamed after that without a new open land from column 0 of the same page.
- R11: Staged bytes that would fall at a column at or past the end of the row are dropped.
- R12: When more than one request is raised in the same idle cycle, erase wins over commit and commit wins over load. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | ADDR_SHIFT+clog2(NUM_PAGES)+1 | Address for open, erase and load (page index above column) |
| pgm_open | input | 1 | Start a program: capture page and column, clear the staging image |
| pgm_valid | input | 1 | A staged data byte is present this cycle |
| pgm_byte | input | 8 | Staged data byte |
| pgm_commit | input | 1 | AND the staging image into the captured page |
| erase_req | input | 1 | Erase the block that holds the addressed page |
| load_req | input | 1 | Stream the addressed page out from its column |
| spare_off | input | 1 | Leave the spare bytes out of a load |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle pulse after busy ends |
| rd_valid | output | 1 | Streamed byte valid |
| rd_byte | output | 8 | Streamed byte |
| rd_last | output | 1 | Final byte of the stream |

## Verification
The bench programs the same column twice with different patterns. A design that overwrote instead of ANDing would keep the second pattern, and the expected value shows the difference. Streams are sent across the main/spare boundary and past the end of the row, so a wrong spare size or a missing end-of-row clip gives the wrong byte count or corrupts data. An erase is given an address with a nonzero page-in-block and column. A design that does not align down would leave pages of the block intact or wipe a neighbouring block. Out-of-range pages are chosen so that their truncated index aliases a real page, and a dropped range check would then modify that page. Further cases cover requests raised during busy, requests raised together in one cycle, and a commit with no new open after a previous commit, to catch a missed clear of the write column.

// File: rtl/nand_store_pkg.sv
package nand_store_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_BUSY   = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_e;

    // Which array operation the sequencer granted this cycle.
    typedef struct packed {
        logic erase;
        logic commit;
    } grant_t;

    // Spare area size that belongs to a main area of pb bytes.
    function automatic int spare_bytes(input int pb);
        return pb >> 5;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_addr_map.sv
module nand_addr_map #(
    parameter int ADDR_SHIFT = 8,
    parameter int NUM_PAGES  = 8,
    parameter int PAGE_W     = 4,
    parameter int CW         = 10
) (
    input  logic [ADDR_SHIFT+PAGE_W-1:0] addr,
    output logic [PAGE_W-1:0]            page_idx,
    output logic [CW-1:0]                col,
    output logic                         page_ok
);
    always_comb begin
        page_idx = addr[ADDR_SHIFT+PAGE_W-1:ADDR_SHIFT];
        col      = CW'(addr[ADDR_SHIFT-1:0]);
        page_ok  = page_idx < PAGE_W'(NUM_PAGES);
    end
endmodule

// File: rtl/nand_stage_buf.sv
module nand_stage_buf #(
    parameter int ROW_BYTES = 264,
    parameter int PAGE_W    = 4,
    parameter int CW        = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       open_i,
    input  logic [PAGE_W-1:0]          start_page,
    input  logic [CW-1:0]              start_col,
    input  logic                       clear_i,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_byte,
    output logic [ROW_BYTES-1:0][7:0]  image,
    output logic [PAGE_W-1:0]          page_o
);
    localparam int COL_W = $clog2(ROW_BYTES);

    logic [CW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            image  <= '1;
            ptr    <= '0;
            page_o <= '0;
        end else if (open_i) begin
            image  <= '1;
            ptr    <= start_col;
            page_o <= start_page;
        end else if (clear_i) begin
            image  <= '1;
            ptr    <= '0;
        end else if (wr_en && (ptr < CW'(ROW_BYTES))) begin
            image[ptr[COL_W-1:0]] <= wr_byte;
            ptr                   <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
    parameter int NUM_PAGES   = 8,
    parameter int ROW_BYTES   = 264,
    parameter int ERASE_SHIFT = 2,
    parameter int PAGE_W      = 4,
    parameter int CW          = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pgm_en,
    input  logic [PAGE_W-1:0]         pgm_page,
    input  logic [ROW_BYTES-1:0][7:0] pgm_image,
    input  logic                      ers_en,
    input  logic [PAGE_W-1:0]         ers_page,
    input  logic [PAGE_W-1:0]         rd_page,
    input  logic [CW-1:0]             rd_col,
    output logic [7:0]                rd_byte
);
    localparam int COL_W = $clog2(ROW_BYTES);
    localparam int PIW   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic [7:0] cells [NUM_PAGES][ROW_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PAGES; p++)
                for (int c = 0; c < ROW_BYTES; c++)
                    cells[p][c] <= 8'hFF;
        end else begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                if (ers_en && ((p >> ERASE_SHIFT) == (int'(ers_page) >> ERASE_SHIFT))) begin
                    for (int c = 0; c < ROW_BYTES; c++)
                        cells[p][c] <= 8'hFF;
                end else if (pgm_en && (int'(pgm_page) == p)) begin
                    for (int c = 0; c < ROW_BYTES; c++)
                        cells[p][c] <= cells[p][c] & pgm_image[c];
                end
            end
        end
    end

    always_comb begin
        rd_byte = 8'hFF;
        if ((int'(rd_page) < NUM_PAGES) && (int'(rd_col) < ROW_BYTES))
            rd_byte = cells[rd_page[PIW-1:0]][rd_col[COL_W-1:0]];
    end
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_store_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int ROW_BYTES   = 264,
    parameter int BUSY_CYCLES = 4,
    parameter int PAGE_W      = 4,
    parameter int CW          = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_req,
    input  logic              commit_req,
    input  logic              load_req,
    input  logic              commit_ok,
    input  logic              page_ok,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [CW-1:0]     req_col,
    input  logic              spare_off,
    output grant_t            grant,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [PAGE_W-1:0] rd_page,
    output logic [CW-1:0]     rd_col
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES + 1) : 1;

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [CW-1:0]     rd_end;
    logic [CW-1:0]     limit;
    logic              idle;
    logic              take_load;

    always_comb begin
        idle         = (state == SEQ_IDLE);
        limit        = spare_off ? CW'(PAGE_BYTES) : CW'(ROW_BYTES);
        grant.erase  = idle && erase_req && page_ok;
        grant.commit = idle && !erase_req && commit_req && commit_ok;
        take_load    = idle && !erase_req && !commit_req && load_req
                       && page_ok && (req_col < limit);
        busy         = (state == SEQ_BUSY);
        rd_valid     = (state == SEQ_STREAM);
        rd_last      = rd_valid && (rd_col == rd_end - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            done    <= 1'b0;
            rd_page <= '0;
            rd_col  <= '0;
            rd_end  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (grant.erase || grant.commit) begin
                        state <= SEQ_BUSY;
                        cnt   <= CNT_W'(BUSY_CYCLES - 1);
                    end else if (take_load) begin
                        state   <= SEQ_STREAM;
                        rd_page <= req_page;
                        rd_col  <= req_col;
                        rd_end  <= limit;
                    end
                end
                SEQ_BUSY: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_STREAM: begin
                    if (rd_last) state  <= SEQ_IDLE;
                    else         rd_col <= rd_col + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
    import nand_store_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int ADDR_SHIFT  = 8,
    parameter int NUM_PAGES   = 8,
    parameter int ERASE_SHIFT = 2,
    parameter int BUSY_CYCLES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [ADDR_SHIFT+$clog2(NUM_PAGES):0] req_addr,
    input  logic                                  pgm_open,
    input  logic                                  pgm_valid,
    input  logic [7:0]                            pgm_byte,
    input  logic                                  pgm_commit,
    input  logic                                  erase_req,
    input  logic                                  load_req,
    input  logic                                  spare_off,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  rd_valid,
    output logic [7:0]                            rd_byte,
    output logic                                  rd_last
);
    localparam int SPARE     = spare_bytes(PAGE_BYTES);
    localparam int ROW_BYTES = PAGE_BYTES + SPARE;
    localparam int COL_W     = $clog2(ROW_BYTES);
    localparam int CW        = max_int(COL_W, ADDR_SHIFT) + 1;
    localparam int PAGE_W    = $clog2(NUM_PAGES) + 1;

    logic [PAGE_W-1:0]         req_page;
    logic [CW-1:0]             req_col;
    logic                      page_ok;
    logic [ROW_BYTES-1:0][7:0] image;
    logic [PAGE_W-1:0]         stage_page;
    logic                      commit_ok;
    grant_t                    grant;
    logic [PAGE_W-1:0]         rd_page;
    logic [CW-1:0]             rd_col;
    logic [7:0]                arr_byte;

    assign commit_ok = stage_page < PAGE_W'(NUM_PAGES);
    assign rd_byte   = rd_valid ? arr_byte : 8'h00;

    nand_addr_map #(
        .ADDR_SHIFT(ADDR_SHIFT), .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .CW(CW)
    ) u_map (
        .addr(req_addr), .page_idx(req_page), .col(req_col), .page_ok(page_ok)
    );

    nand_stage_buf #(
        .ROW_BYTES(ROW_BYTES), .PAGE_W(PAGE_W), .CW(CW)
    ) u_stage (
        .clk(clk), .rst(rst),
        .open_i(pgm_open), .start_page(req_page), .start_col(req_col),
        .clear_i(grant.commit), .wr_en(pgm_valid), .wr_byte(pgm_byte),
        .image(image), .page_o(stage_page)
    );

    nand_seq_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .ROW_BYTES(ROW_BYTES), .BUSY_CYCLES(BUSY_CYCLES),
        .PAGE_W(PAGE_W), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst),
        .erase_req(erase_req), .commit_req(pgm_commit), .load_req(load_req),
        .commit_ok(commit_ok), .page_ok(page_ok),
        .req_page(req_page), .req_col(req_col), .spare_off(spare_off),
        .grant(grant), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_page(rd_page), .rd_col(rd_col)
    );

    nand_cell_array #(
        .NUM_PAGES(NUM_PAGES), .ROW_BYTES(ROW_BYTES), .ERASE_SHIFT(ERASE_SHIFT),
        .PAGE_W(PAGE_W), .CW(CW)
    ) u_cells (
        .clk(clk), .rst(rst),
        .pgm_en(grant.commit), .pgm_page(stage_page), .pgm_image(image),
        .ers_en(grant.erase), .ers_page(req_page),
        .rd_page(rd_page), .rd_col(rd_col), .rd_byte(arr_byte)
    );
endmodule

// File: rtl/nand_page_store_chk.sv
module nand_page_store_chk #(
    parameter int BUSY_CYCLES = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic rd_valid,
    input logic rd_last
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < BUSY_CYCLES));

    // R9
    busy_blocks_stream_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid);

    // R9
    stream_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !busy);

    // R6
    last_in_stream_chk: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    // R6
    stream_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_last) |=> rd_valid);
endmodule

bind nand_page_store nand_page_store_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_last(rd_last)
);

// File: tb/tb_nand_page_store.sv
module tb_nand_page_store;
    localparam int PB  = 256;
    localparam int AS  = 8;
    localparam int NP  = 8;
    localparam int ES  = 2;
    localparam int BC  = 4;
    localparam int ROW = PB + (PB >> 5);
    localparam int AW  = AS + $clog2(NP) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] req_addr = '0;
    logic          pgm_open = 0, pgm_valid = 0, pgm_commit = 0;
    logic [7:0]    pgm_byte = '0;
    logic          erase_req = 0, load_req = 0, spare_off = 0;
    logic          busy, done, rd_valid, rd_last;
    logic [7:0]    rd_byte;

    int compared = 0;
    int mismatched = 0;
    int busy_seen = 0;
    int done_seen = 0;
    byte unsigned cap[$];

    always #2 clk = ~clk;

    nand_page_store #(.PAGE_BYTES(PB), .ADDR_SHIFT(AS), .NUM_PAGES(NP),
                      .ERASE_SHIFT(ES), .BUSY_CYCLES(BC)) dut (
        .clk(clk), .rst(rst), .req_addr(req_addr), .pgm_open(pgm_open),
        .pgm_valid(pgm_valid), .pgm_byte(pgm_byte), .pgm_commit(pgm_commit),
        .erase_req(erase_req), .load_req(load_req), .spare_off(spare_off),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .rd_last(rd_last)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int           m_state;   // 0 idle, 1 busy, 2 stream
    int           m_cnt;
    bit           m_done;
    byte unsigned m_mem[NP*ROW];
    byte unsigned m_buf[ROW];
    int           m_ptr, m_spage;
    int           s_page, s_col, s_end;

    always @(posedge clk) begin : model
        int  pg, cl, lim;
        bit  commit_acc;
        pg = int'(req_addr) >> AS;
        cl = int'(req_addr) & ((1 << AS) - 1);
        commit_acc = 0;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            foreach (m_buf[i]) m_buf[i] = 8'hFF;
            m_ptr = 0; m_spage = 0; m_state = 0; m_cnt = 0; m_done = 0;
            s_page = 0; s_col = 0; s_end = 0;
        end else begin
            m_done = 0;
            if (m_state == 1) begin
                if (m_cnt == 0) begin m_state = 0; m_done = 1; end
                else m_cnt--;
            end else if (m_state == 2) begin
                if (s_col == s_end - 1) m_state = 0;
                else s_col++;
            end else begin
                lim = spare_off ? PB : ROW;
                if (erase_req) begin
                    if (pg < NP) begin
                        for (int p = 0; p < NP; p++)
                            if ((p >> ES) == (pg >> ES))
                                for (int c = 0; c < ROW; c++) m_mem[p*ROW+c] = 8'hFF;
                        m_state = 1; m_cnt = BC - 1;
                    end
                end else if (pgm_commit) begin
                    if (m_spage < NP) begin
                        for (int c = 0; c < ROW; c++)
                            m_mem[m_spage*ROW+c] = m_mem[m_spage*ROW+c] & m_buf[c];
                        commit_acc = 1;
                        m_state = 1; m_cnt = BC - 1;
                    end
                end else if (load_req) begin
                    if (pg < NP && cl < lim) begin
                        m_state = 2; s_page = pg; s_col = cl; s_end = lim;
                    end
                end
            end
            if (pgm_open) begin
                foreach (m_buf[i]) m_buf[i] = 8'hFF;
                m_ptr = cl; m_spage = pg;
            end else if (commit_acc) begin
                foreach (m_buf[i]) m_buf[i] = 8'hFF;
                m_ptr = 0;
            end else if (pgm_valid && m_ptr < ROW) begin
                m_buf[m_ptr] = pgm_byte;
                m_ptr++;
            end
        end
    end

    // per-cycle comparison and observation, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8", "busy", busy, m_state == 1);
            chk("R8", "done", done, m_done);
            chk("R6", "rd_valid", rd_valid, m_state == 2);
            chk("R6", "rd_last", rd_last, (m_state == 2) && (s_col == s_end - 1));
            if (m_state == 2) chk("R2", "rd_byte", rd_byte, m_mem[s_page*ROW+s_col]);
            if (busy) busy_seen++;
            if (done) done_seen++;
            if (rd_valid) cap.push_back(rd_byte);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [AW-1:0] addr_of(input int page, input int col);
        return AW'((page << AS) | col);
    endfunction

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy || rd_valid || done) @(negedge clk);
    endtask

    task automatic stream_bytes(input byte unsigned d[$]);
        foreach (d[i]) begin
            pgm_valid = 1; pgm_byte = d[i];
            @(negedge clk); #1;
        end
        pgm_valid = 0;
    endtask

    task automatic commit();
        pgm_commit = 1;
        @(negedge clk); #1;
        pgm_commit = 0;
        wait_idle();
    endtask

    task automatic prog(input int page, input int col, input byte unsigned d[$]);
        @(negedge clk); #1;
        pgm_open = 1; req_addr = addr_of(page, col);
        @(negedge clk); #1;
        pgm_open = 0;
        stream_bytes(d);
        commit();
    endtask

    task automatic do_load(input int page, input int col, input bit so);
        @(negedge clk); #1;
        cap.delete();
        load_req = 1; spare_off = so; req_addr = addr_of(page, col);
        @(negedge clk); #1;
        load_req = 0; spare_off = 0;
        wait_idle();
    endtask

    task automatic do_erase(input int page, input int col);
        @(negedge clk); #1;
        busy_seen = 0; done_seen = 0;
        erase_req = 1; req_addr = addr_of(page, col);
        @(negedge clk); #1;
        erase_req = 0;
        wait_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        int bad;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "rd_valid after reset", rd_valid, 0);
        do_load(0, 0, 0);
        chk("R6", "full row length", cap.size(), ROW);
        bad = 0;
        foreach (cap[i]) if (cap[i] != 8'hFF) bad++;
        chk("R1", "non-FF bytes after reset", bad, 0);

        // R2 AND semantics, R4 column placement
        prog(1, 4, '{8'hF0, 8'h3C});
        prog(1, 4, '{8'h5A, 8'h0F});
        do_load(1, 4, 1);
        chk("R6", "length with spare off", cap.size(), PB - 4);
        chk("R2", "col4 AND", cap[0], 8'h50);
        chk("R2", "col5 AND", cap[1], 8'h0C);
        chk("R2", "col6 untouched", cap[2], 8'hFF);

        // R3 stream into spare area
        prog(2, 250, '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09});
        do_load(2, 250, 0);
        chk("R3", "length from col 250", cap.size(), ROW - 250);
        chk("R3", "first spare byte", cap[6], 8'h06);
        chk("R3", "spare byte 3", cap[9], 8'h09);
        chk("R3", "last spare byte", cap[13], 8'hFF);
        do_load(2, 250, 1);
        chk("R6", "length col 250 spare off", cap.size(), PB - 250);
        do_load(3, 250, 0);
        chk("R4", "neighbour page untouched", cap[0], 8'hFF);

        // R11 clip at row end
        prog(3, 255, '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
                       8'hA8, 8'hA9, 8'hAA, 8'hAB});
        do_load(3, 255, 0);
        chk("R11", "length col 255", cap.size(), 9);
        chk("R11", "last kept byte", cap[8], 8'hA8);

        // R10 column cleared after commit, same page kept
        @(negedge clk); #1;
        stream_bytes('{8'h11, 8'h22});
        commit();
        do_load(3, 0, 0);
        chk("R10", "col0 after reopenless program", cap[0], 8'h11);
        chk("R10", "col1 after reopenless program", cap[1], 8'h22);
        chk("R10", "col2 untouched", cap[2], 8'hFF);

        // R5 block erase with unaligned address, R8 busy length
        prog(5, 0, '{8'hC3});
        do_erase(2, 8'h33);
        chk("R8", "busy cycles", busy_seen, BC);
        chk("R8", "done pulses", done_seen, 1);
        do_load(1, 4, 1);
        chk("R5", "page1 erased", cap[0], 8'hFF);
        do_load(3, 255, 0);
        chk("R5", "spare erased", cap[8], 8'hFF);
        do_load(5, 0, 0);
        chk("R5", "other block kept", cap[0], 8'hC3);

        // R7 out of range requests
        busy_seen = 0;
        prog(9, 0, '{8'h00});
        chk("R7", "busy on bad commit", busy_seen, 0);
        do_load(12, 0, 0);
        chk("R7", "stream on bad load", cap.size(), 0);
        do_erase(8, 0);
        chk("R7", "busy on bad erase", busy_seen, 0);
        do_load(1, 0, 0);
        chk("R7", "aliased page untouched", cap[0], 8'hFF);

        // R9 requests while busy dropped
        @(negedge clk); #1;
        cap.delete();
        erase_req = 1; req_addr = addr_of(0, 0);
        @(negedge clk); #1;
        erase_req = 0; load_req = 1; req_addr = addr_of(5, 0);
        @(negedge clk); #1;
        load_req = 0; erase_req = 1; req_addr = addr_of(5, 0);
        @(negedge clk); #1;
        erase_req = 0;
        wait_idle();
        chk("R9", "stream during busy", cap.size(), 0);
        do_load(5, 0, 0);
        chk("R9", "erase during busy dropped", cap[0], 8'hC3);

        // R12 erase wins over load
        @(negedge clk); #1;
        cap.delete(); busy_seen = 0;
        erase_req = 1; load_req = 1; req_addr = addr_of(6, 0);
        @(negedge clk); #1;
        erase_req = 0; load_req = 0;
        wait_idle();
        chk("R12", "load lost to erase", cap.size(), 0);
        chk("R12", "erase taken", busy_seen, BC);
        do_load(5, 0, 0);
        chk("R5", "block1 erased", cap[0], 8'hFF);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule